// File: doc/BRIEF.md
# Exception Vector Dispatch Unit

This unit converts an exception level into a handler lookup. When a caller presents a level with a request, the unit checks that the level lies inside the vector table. It then computes the vector's byte address from a fixed table base and issues one read on a synchronous memory port. When the descriptor comes back, the unit splits it into a word-aligned handler address and a 2-bit type code.

An all-zero descriptor marks an unassigned vector. The unit reports that case so the caller can fall back to its built-in default action and does not jump to a handler. A level beyond the end of the table completes at once with an error flag, and no memory read is issued.

Only one lookup is in progress at a time. While a lookup runs, `busy` is high and new requests are ignored. Results are held on the outputs from one `done` pulse until the next.

Top module: `vec_dispatch`

## Requirements
- R1: While `rd_en` is high, `rd_addr` equals 0x80000040 + 4 × the accepted level.
- R2: An accepted in-range request raises `rd_en` for exactly one cycle, in the cycle after the request is accepted.
- R3: `rd_data` is captured one cycle after the read is issued, and `done` is high for exactly one cycle, in the cycle after that capture.
- R4: At `done`, `hdl_addr` equals the descriptor with bits 1:0 forced to zero.
- R5: At `done`, `hdl_type` equals descriptor bits 1:0.
- R6: At `done`, `is_null` is 1 exactly when the descriptor is the all-zero word. A non-zero descriptor with a zero address part is not null.
- R7: A level of 48 or more gives `done` with `lvl_err`=1 in the cycle after acceptance, with no read issued. `hdl_addr`, `hdl_type` and `is_null` read 0. An in-range lookup gives `lvl_err`=0.
- R8: `busy` is high from the cycle after acceptance through the `done` cycle. Requests presented while `busy` is high are ignored.
- R9: After reset, `busy`, `done`, `rd_en`, `lvl_err`, `is_null`, `hdl_addr` and `hdl_type` are all 0.
- R10: `hdl_addr`, `hdl_type`, `is_null` and `lvl_err` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Lookup request, accepted when `busy` is low |
| level | input | 6 | Exception level (word index into the table) |
| busy | output | 1 | Lookup in progress |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 32 | Memory byte address of the vector |
| rd_data | input | 32 | Memory read data, valid one cycle after `rd_en` |
| done | output | 1 | One-cycle completion pulse |
| hdl_addr | output | 32 | Word-aligned handler address |
| hdl_type | output | 2 | Descriptor type code |
| is_null | output | 1 | Vector is unassigned; use the default action |
| lvl_err | output | 1 | Level beyond the table end |

## Verification
The in-RTL assertions check the following on every cycle:
- the read strobe and completion pulse each last a single cycle;
- the read address stays aligned and inside the table;
- `busy` covers each completion;
- an error completion never follows a read;
- a null result carries zero fields;
- the result outputs never change outside a completion.

The bench scenarios are needed for the behaviour that depends on memory contents and on timing across several cycles. These are the exact address value per level, the decoded fields against a random table with null and zero-address entries, the error path at levels 48 and 63, and the fact that requests presented while busy start no read.

// File: rtl/vecdisp_pkg.sv
package vecdisp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_FIN
    } disp_state_e;
endpackage

// File: rtl/vd_addr_gen.sv
module vd_addr_gen #(
    parameter int          LEVEL_W    = 6,
    parameter int          NUM_LEVELS = 48,
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] TABLE_BASE = 32'h8000_0040
) (
    input  logic [LEVEL_W-1:0] level_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               in_range_o
);
    localparam int OFS_W = LEVEL_W + 2;

    logic [OFS_W-1:0] byte_ofs;

    always_comb begin
        byte_ofs   = {level_i, 2'b00};
        addr_o     = ADDR_W'(TABLE_BASE) + ADDR_W'(byte_ofs);
        in_range_o = (32'(level_i) < NUM_LEVELS);
    end
endmodule

// File: rtl/vd_desc_decode.sv
module vd_desc_decode #(
    parameter int ADDR_W = 32,
    parameter int TYPE_W = 2
) (
    input  logic [ADDR_W-1:0] desc_i,
    output logic [ADDR_W-1:0] haddr_o,
    output logic [TYPE_W-1:0] htype_o,
    output logic              null_o
);
    always_comb begin
        haddr_o = {desc_i[ADDR_W-1:TYPE_W], {TYPE_W{1'b0}}};
        htype_o = desc_i[TYPE_W-1:0];
        null_o  = (desc_i == '0);
    end
endmodule

// File: rtl/vec_dispatch.sv
module vec_dispatch #(
    parameter int          LEVEL_W    = 6,
    parameter int          NUM_LEVELS = 48,
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] TABLE_BASE = 32'h8000_0040
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [LEVEL_W-1:0] level,
    output logic               busy,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [ADDR_W-1:0]  rd_data,
    output logic               done,
    output logic [ADDR_W-1:0]  hdl_addr,
    output logic [1:0]         hdl_type,
    output logic               is_null,
    output logic               lvl_err
);
    import vecdisp_pkg::*;

    localparam int TYPE_W   = 2;
    localparam int TBL_SPAN = NUM_LEVELS * 4;

    typedef struct packed {
        disp_state_e        state;
        logic               rd_en;
        logic [ADDR_W-1:0]  addr;
        logic               done;
        logic [ADDR_W-1:0]  haddr;
        logic [TYPE_W-1:0]  htype;
        logic               nul;
        logic               err;
    } disp_regs_t;

    disp_regs_t r_d, r_q;

    logic [ADDR_W-1:0] gen_addr;
    logic              gen_ok;
    logic [ADDR_W-1:0] dec_haddr;
    logic [TYPE_W-1:0] dec_htype;
    logic              dec_null;

    vd_addr_gen #(
        .LEVEL_W   (LEVEL_W),
        .NUM_LEVELS(NUM_LEVELS),
        .ADDR_W    (ADDR_W),
        .TABLE_BASE(TABLE_BASE)
    ) addr_gen_i (
        .level_i   (level),
        .addr_o    (gen_addr),
        .in_range_o(gen_ok)
    );

    vd_desc_decode #(
        .ADDR_W(ADDR_W),
        .TYPE_W(TYPE_W)
    ) decode_i (
        .desc_i (rd_data),
        .haddr_o(dec_haddr),
        .htype_o(dec_htype),
        .null_o (dec_null)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rd_en = 1'b0;
        r_d.done  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req) begin
                    if (gen_ok) begin
                        r_d.state = ST_READ;
                        r_d.rd_en = 1'b1;
                        r_d.addr  = gen_addr;
                    end else begin
                        r_d.state = ST_FIN;
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b1;
                        r_d.nul   = 1'b0;
                        r_d.haddr = '0;
                        r_d.htype = '0;
                    end
                end
            end
            ST_READ: r_d.state = ST_WAIT;
            ST_WAIT: begin
                r_d.state = ST_FIN;
                r_d.done  = 1'b1;
                r_d.haddr = dec_haddr;
                r_d.htype = dec_htype;
                r_d.nul   = dec_null;
                r_d.err   = 1'b0;
            end
            ST_FIN:  r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, rd_en: 1'b0, addr: '0, done: 1'b0,
                     haddr: '0, htype: '0, nul: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.state != ST_IDLE);
    assign rd_en    = r_q.rd_en;
    assign rd_addr  = r_q.addr;
    assign done     = r_q.done;
    assign hdl_addr = r_q.haddr;
    assign hdl_type = r_q.htype;
    assign is_null  = r_q.nul;
    assign lvl_err  = r_q.err;

    // R1: read address aligned and within the table
    p_addr_in_table_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr[1:0] == 2'b00) && (rd_addr >= ADDR_W'(TABLE_BASE))
                  && (rd_addr < ADDR_W'(TABLE_BASE) + ADDR_W'(TBL_SPAN)));

    p_rd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_null_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_null) |-> (hdl_addr == '0) && (hdl_type == '0) && !lvl_err);

    p_err_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lvl_err) |-> !rd_en && !$past(rd_en));

    p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || rd_en) |-> busy);

    p_hold_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(hdl_addr) && $stable(hdl_type)
                  && $stable(is_null) && $stable(lvl_err));
endmodule

// File: tb/vec_dispatch_tb_top.sv
`timescale 1ns/1ps
module vec_dispatch_tb_top;
    localparam logic [31:0] BASE = 32'h8000_0040;
    localparam int          NLVL = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [5:0]  level = '0;
    logic        busy, rd_en, done, is_null, lvl_err;
    logic [31:0] rd_addr, hdl_addr;
    logic [31:0] rd_data = '0;
    logic [1:0]  hdl_type;

    logic [31:0] tbl [64];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vec_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .level(level),
        .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .hdl_addr(hdl_addr), .hdl_type(hdl_type),
        .is_null(is_null), .lvl_err(lvl_err)
    );

    always @(posedge clk) begin
        if (rd_en) rd_data <= tbl[6'((rd_addr - BASE) >> 2)];
    end

    function automatic logic [31:0] exp_vaddr(int lvl);
        return BASE + 32'(lvl) * 32'd4;
    endfunction
    function automatic logic [31:0] exp_haddr(logic [31:0] d);
        return d & 32'hFFFF_FFFC;
    endfunction

    task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic lookup(int lvl, bit poke);
        logic [31:0] pa, d;
        logic [1:0]  pt;
        logic        pn, pe;
        pa = hdl_addr; pt = hdl_type; pn = is_null; pe = lvl_err;
        d = tbl[lvl];
        @(negedge clk);
        req = 1'b1; level = 6'(lvl);
        @(negedge clk);
        req = poke; level = 6'($urandom_range(0, 63));
        chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 1);
        if (lvl < NLVL) begin
            chk(rd_en == 1'b1, "R2 read strobe", 32'(rd_en), 1);
            chk(rd_addr == exp_vaddr(lvl), "R1 vector address", rd_addr, exp_vaddr(lvl));
            chk(done == 1'b0, "R3 no early done", 32'(done), 0);
            @(negedge clk);
            chk(rd_en == 1'b0, "R2 strobe one cycle", 32'(rd_en), 0);
            chk(done == 1'b0, "R3 done not yet", 32'(done), 0);
            chk(hdl_addr == pa && hdl_type == pt && is_null == pn && lvl_err == pe,
                "R10 outputs held", hdl_addr, pa);
            @(negedge clk);
            req = 1'b0;
            chk(done == 1'b1, "R3 done pulse", 32'(done), 1);
            chk(busy == 1'b1, "R8 busy at done", 32'(busy), 1);
            chk(hdl_addr == exp_haddr(d), "R4 handler address", hdl_addr, exp_haddr(d));
            chk(hdl_type == d[1:0], "R5 type code", 32'(hdl_type), 32'(d[1:0]));
            chk(is_null == (d == 0), "R6 null flag", 32'(is_null), 32'(d == 0));
            chk(lvl_err == 1'b0, "R7 no error in range", 32'(lvl_err), 0);
        end else begin
            chk(done == 1'b1, "R7 error done", 32'(done), 1);
            chk(lvl_err == 1'b1, "R7 error flag", 32'(lvl_err), 1);
            chk(rd_en == 1'b0, "R7 no read", 32'(rd_en), 0);
            chk(hdl_addr == 0 && hdl_type == 0 && is_null == 0, "R7 zero fields", hdl_addr, 0);
        end
        pa = hdl_addr; pt = hdl_type; pn = is_null; pe = lvl_err;
        @(negedge clk);
        req = 1'b0;
        chk(done == 1'b0, "R3 done one cycle", 32'(done), 0);
        chk(busy == 1'b0, "R8 idle after done", 32'(busy), 0);
        chk(rd_en == 1'b0, "R8 busy request ignored", 32'(rd_en), 0);
        @(negedge clk);
        chk(rd_en == 1'b0 && done == 1'b0, "R8 no late start", 32'(rd_en | done), 0);
        chk(hdl_addr == pa && hdl_type == pt && is_null == pn && lvl_err == pe,
            "R10 results kept", hdl_addr, pa);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            tbl[i] = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom();
        end
        tbl[0]  = 32'h0;
        tbl[1]  = 32'h0000_0003;
        tbl[2]  = 32'hFFFF_FFFF;
        tbl[47] = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && rd_en == 0, "R9 reset control", 32'({busy, done, rd_en}), 0);
        chk(hdl_addr == 0 && hdl_type == 0 && is_null == 0 && lvl_err == 0,
            "R9 reset results", hdl_addr, 0);
        lookup(0, 1'b0);
        lookup(1, 1'b1);
        lookup(2, 1'b0);
        lookup(47, 1'b1);
        lookup(48, 1'b1);
        lookup(63, 1'b0);
        lookup(5, 1'b0);
        for (int n = 0; n < 60; n++) begin
            lookup($urandom_range(0, 63), 1'($urandom_range(0, 1)));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule